// File: doc/BRIEF.md
# Card Bring-Up Command Sequencer

This block is a host-side controller that takes a managed-flash memory card from power-up idle into data-transfer mode and then starts a multi-block read of boot code. It never touches the serial command line itself. For each step it presents a 6-bit command index and a 32-bit argument to a separate command-frame transmitter. It holds them until the transmitter accepts, and then waits for that transmitter's response-valid strobe carrying 32 response bits.

The sequence has two parts. The identification part runs at the slow clock: reset-to-idle, a polled operating-condition request, an identification read and a relative-address assignment. The transfer part runs at the fast clock: card select, two register-write switches (bus width and high-speed timing), block length, multi-block read, stop and a final status query. An external block counter tells the sequencer when the read has delivered enough blocks. The sequencer ends in a done state. If the card never reports ready within a programmable number of polls, it ends in a halted error state instead.

Top module: `card_init_seq`

## Requirements
- R1: Reset state: `cmd_valid`=0, `done`=0, `error`=0 and `slow_clk_sel`=1.
- R2: After `start`, the identification commands come in this order: index 0 (argument 0, no response awaited), index 1 (argument OCR_ARG), index 2 (argument 0), index 3 (argument RCA in [31:16], zero in [15:0]).
- R3: Index 1 is reissued, with the same argument, each time its response has bit 31 equal to 0. The sequence moves on to index 2 when bit 31 is 1.
- R4: Index 1 is sent at most `retry_limit` times (a limit of 0 acts as 1). If the last allowed response is still not ready, `error` rises, no further command is issued, and `error` stays high until reset. A ready response on the last allowed attempt counts as success.
- R5: `slow_clk_sel` is 1 from reset or `start` until the response to index 3 arrives, and 0 afterwards. Every command with index 0 to 3 goes out with it high, and every later command goes out with it low.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_idx` and `cmd_arg` hold their values.
- R7: Register-write commands (index 6) pack access mode 2'b11 in [25:24], byte index in [23:16], value in [15:8], command set 0 in [2:0] and zeros elsewhere. The bus-width switch is 0x03B70200 (byte 183, value 0x02) and the timing switch is 0x03B90100 (byte 185, value 0x01).
- R8: The transfer-mode order is: index 7 (RCA<<16), index 6 width, index 6 timing, index 16 (BLK_LEN), index 18 (`boot_addr`), index 12 (argument 0), index 13 (RCA<<16).
- R9: After the response to index 18, nothing is issued until `blocks_done` is seen high. Index 12 then follows. `blocks_done` at any other time has no effect.
- R10: `done` rises after the response to index 13. `rsp_valid` has no effect while no response is awaited, and `done` and `error` are never high together.
- R11: `start` in the done state clears `done` and restarts the whole sequence from index 0 with the slow clock selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or rerun) the bring-up sequence |
| retry_limit | input | RETRY_W | Maximum number of operating-condition polls |
| boot_addr | input | 32 | Start address for the multi-block read |
| cmd_valid | output | 1 | Command index and argument are presented |
| cmd_ready | input | 1 | Transmitter accepts the presented command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response bits are valid this cycle |
| rsp_bits | input | 32 | Response payload |
| blocks_done | input | 1 | External counter reached the requested block count |
| slow_clk_sel | output | 1 | 1 selects the identification-rate clock |
| done | output | 1 | Sequence finished |
| error | output | 1 | Polling budget exhausted; block halted |

## Verification
Two outcomes can land on the same response cycle: the card reporting ready, and the poll budget running out. The bench provokes this with a limit of 2, answering the first poll not-ready and the second ready. It judges the result by seeing index 2 issued with `error` still low. A separate run with a limit of 3 and three not-ready answers must raise `error` and then stay silent on the command port, even when `start` is pulsed. Stray `rsp_valid` and early `blocks_done` pulses are injected while the sequencer is waiting for something else, and the ordered command stream must come out unchanged.

// File: rtl/cis_pkg.sv
package cis_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_OPCOND, ST_IDENT, ST_ADDR, ST_SELECT, ST_WIDTH,
    ST_TIMING, ST_BLKLEN, ST_READ, ST_STOP, ST_STATUS
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_ISSUE, PH_WAIT, PH_BLOCKS, PH_DONE, PH_ERR
  } phase_e;

  localparam logic [1:0] ACC_WRITE_BYTE = 2'b11;
  localparam int         OCR_READY_BIT  = 31;

  function automatic logic [31:0] pack_switch(input logic [1:0] acc,
                                              input logic [7:0] byte_idx,
                                              input logic [7:0] value,
                                              input logic [2:0] cset);
    return {6'b0, acc, byte_idx, value, 5'b0, cset};
  endfunction

endpackage

// File: rtl/cis_cmd_table.sv
module cis_cmd_table
  import cis_pkg::*;
#(
  parameter int          RCA_W       = 16,
  parameter logic [15:0] RCA         = 16'h0001,
  parameter int          BLK_LEN     = 512,
  parameter logic [31:0] OCR_ARG     = 32'h00FF_8000,
  parameter logic [7:0]  WIDTH_BYTE  = 8'd183,
  parameter logic [7:0]  WIDTH_VAL   = 8'h02,
  parameter logic [7:0]  TIMING_BYTE = 8'd185,
  parameter logic [7:0]  TIMING_VAL  = 8'h01
) (
  input  step_e       step,
  input  logic [31:0] boot_addr,
  output logic [5:0]  idx,
  output logic [31:0] arg,
  output logic        wants_rsp
);
  localparam int          STUFF_W = 32 - RCA_W;
  localparam logic [31:0] RCA_ARG = {RCA[RCA_W-1:0], {STUFF_W{1'b0}}};

  always_comb begin
    wants_rsp = 1'b1;
    arg       = '0;
    unique case (step)
      ST_RESET:   begin idx = 6'd0;  wants_rsp = 1'b0; end
      ST_OPCOND:  begin idx = 6'd1;  arg = OCR_ARG; end
      ST_IDENT:   begin idx = 6'd2;  end
      ST_ADDR:    begin idx = 6'd3;  arg = RCA_ARG; end
      ST_SELECT:  begin idx = 6'd7;  arg = RCA_ARG; end
      ST_WIDTH:   begin idx = 6'd6;
                        arg = pack_switch(ACC_WRITE_BYTE, WIDTH_BYTE, WIDTH_VAL, 3'd0); end
      ST_TIMING:  begin idx = 6'd6;
                        arg = pack_switch(ACC_WRITE_BYTE, TIMING_BYTE, TIMING_VAL, 3'd0); end
      ST_BLKLEN:  begin idx = 6'd16; arg = 32'(BLK_LEN); end
      ST_READ:    begin idx = 6'd18; arg = boot_addr; end
      ST_STOP:    begin idx = 6'd12; end
      ST_STATUS:  begin idx = 6'd13; arg = RCA_ARG; end
      default:    begin idx = 6'd0;  wants_rsp = 1'b0; end
    endcase
  end
endmodule

// File: rtl/cis_poll_limit.sv
module cis_poll_limit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] polls;

  always_ff @(posedge clk) begin
    if (rst || clear)                 polls <= '0;
    else if (bump && polls != '1)     polls <= polls + 1'b1;
  end

  // attempt number of the poll now in flight is polls+1
  assign last = (EXT_W'(polls) + EXT_W'(1)) >= EXT_W'(limit);

  p_poll_count_r4: assert property (@(posedge clk) disable iff (rst)
    (bump && !clear && polls != '1) |=> polls == $past(polls) + 1'b1);
endmodule

// File: rtl/card_init_seq.sv
module card_init_seq
  import cis_pkg::*;
#(
  parameter logic [15:0] RCA     = 16'h0001,
  parameter int          BLK_LEN = 512,
  parameter logic [31:0] OCR_ARG = 32'h00FF_8000,
  parameter int          RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic [31:0]        boot_addr,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [5:0]         cmd_idx,
  output logic [31:0]        cmd_arg,
  input  logic               rsp_valid,
  input  logic [31:0]        rsp_bits,
  input  logic               blocks_done,
  output logic               slow_clk_sel,
  output logic               done,
  output logic               error
);
  phase_e      phase;
  step_e       step;
  logic [5:0]  tbl_idx;
  logic [31:0] tbl_arg;
  logic        tbl_rsp;
  logic        poll_last;
  logic        launch;
  logic        poll_miss;

  step_e next_step;
  assign next_step = step_e'(4'(step) + 4'd1);

  assign launch    = start && (phase == PH_IDLE || phase == PH_DONE);
  assign poll_miss = (phase == PH_WAIT) && rsp_valid && (step == ST_OPCOND)
                     && !rsp_bits[OCR_READY_BIT];

  cis_cmd_table #(.RCA(RCA), .BLK_LEN(BLK_LEN), .OCR_ARG(OCR_ARG)) u_table (
    .step(step), .boot_addr(boot_addr),
    .idx(tbl_idx), .arg(tbl_arg), .wants_rsp(tbl_rsp)
  );

  cis_poll_limit #(.CNT_W(RETRY_W)) u_poll (
    .clk(clk), .rst(rst), .clear(launch), .bump(poll_miss),
    .limit(retry_limit), .last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      step         <= ST_RESET;
      cmd_valid    <= 1'b0;
      cmd_idx      <= '0;
      cmd_arg      <= '0;
      slow_clk_sel <= 1'b1;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_DONE: if (start) begin
          step         <= ST_RESET;
          phase        <= PH_LOAD;
          slow_clk_sel <= 1'b1;
          done         <= 1'b0;
        end
        PH_LOAD: begin
          cmd_valid <= 1'b1;
          cmd_idx   <= tbl_idx;
          cmd_arg   <= tbl_arg;
          phase     <= PH_ISSUE;
        end
        PH_ISSUE: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          if (tbl_rsp) phase <= PH_WAIT;
          else begin
            step  <= next_step;
            phase <= PH_LOAD;
          end
        end
        PH_WAIT: if (rsp_valid) begin
          unique case (step)
            ST_OPCOND: begin
              if (rsp_bits[OCR_READY_BIT]) begin
                step  <= ST_IDENT;
                phase <= PH_LOAD;
              end else if (poll_last) begin
                phase <= PH_ERR;
                error <= 1'b1;
              end else phase <= PH_LOAD;
            end
            ST_ADDR: begin
              slow_clk_sel <= 1'b0;
              step         <= next_step;
              phase        <= PH_LOAD;
            end
            ST_READ:   phase <= PH_BLOCKS;
            ST_STATUS: begin
              phase <= PH_DONE;
              done  <= 1'b1;
            end
            default: begin
              step  <= next_step;
              phase <= PH_LOAD;
            end
          endcase
        end
        PH_BLOCKS: if (blocks_done) begin
          step  <= ST_STOP;
          phase <= PH_LOAD;
        end
        PH_ERR: phase <= PH_ERR;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_idx) && $stable(cmd_arg)));

  p_ident_slow_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx <= 6'd3) |-> slow_clk_sel);

  p_data_fast_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx > 6'd3) |-> !slow_clk_sel);

  p_switch_arg_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_idx == 6'd6) |->
      (cmd_arg[31:26] == 6'd0 && cmd_arg[25:24] == 2'b11 && cmd_arg[7:0] == 8'd0));

  p_err_halt_r4: assert property (@(posedge clk) disable iff (rst)
    error |=> (error && !cmd_valid));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  p_stop_gated_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) && cmd_idx == 6'd12 |-> $past(phase == PH_LOAD));
endmodule

// File: tb/card_init_seq_tb.sv
module card_init_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  retry_limit = 8'd4;
  logic [31:0] boot_addr = 32'h0000_0800;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_bits = '0;
  logic        blocks_done = 1'b0;
  logic        slow_clk_sel, done, error;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  card_init_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .retry_limit(retry_limit),
    .boot_addr(boot_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
    .rsp_bits(rsp_bits), .blocks_done(blocks_done),
    .slow_clk_sel(slow_clk_sel), .done(done), .error(error)
  );

  localparam int NV = 12;
  localparam logic [5:0]  V_IDX [NV] = '{6'd0, 6'd1, 6'd1, 6'd2, 6'd3, 6'd7,
                                         6'd6, 6'd6, 6'd16, 6'd18, 6'd12, 6'd13};
  localparam logic [31:0] V_ARG [NV] = '{32'h0, 32'h00FF8000, 32'h00FF8000, 32'h0,
                                         32'h00010000, 32'h00010000, 32'h03B70200,
                                         32'h03B90100, 32'h200, 32'h800, 32'h0,
                                         32'h00010000};
  localparam logic [31:0] V_RSP [NV] = '{32'h0, 32'h00FF8000, 32'h80FF8000, 32'h0,
                                         32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                         32'h0, 32'h0};
  localparam logic        V_SLOW [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                                          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_cmd(input logic [5:0] eidx, input logic [31:0] earg,
                        input logic eslow, input logic [31:0] rsp,
                        input int hold, input string req);
    int n = 0;
    while (!cmd_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(cmd_valid === 1'b1, req, "cmd_valid", 32'(cmd_valid), 32'd1);
    chk(cmd_idx === eidx, req, "cmd_idx", 32'(cmd_idx), 32'(eidx));
    chk(cmd_arg === earg, req, "cmd_arg", cmd_arg, earg);
    chk(slow_clk_sel === eslow, "R5", "slow_clk_sel", 32'(slow_clk_sel), 32'(eslow));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(cmd_valid === 1'b1 && cmd_idx === eidx && cmd_arg === earg,
          "R6", "held command", cmd_arg, earg);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    if (eidx != 6'd0) begin
      rsp_valid = 1'b1;
      rsp_bits  = rsp;
      @(negedge clk);
      rsp_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk(cmd_valid === 1'b0, "R1", "cmd_valid", 32'(cmd_valid), 32'd0);
    chk(done === 1'b0 && error === 1'b0, "R1", "done/error", {done, error}, 32'd0);
    chk(slow_clk_sel === 1'b1, "R1", "slow_clk_sel", 32'(slow_clk_sel), 32'd1);
    rst = 1'b0;
    @(negedge clk);

    // main vector walk: R2 R3 R7 R8, with R6 hold on the first poll
    retry_limit = 8'd4;
    pulse_start();
    for (int i = 0; i < NV; i++) begin
      if (i == 5) blocks_done = 1'b1;   // R9: early blocks_done must be ignored
      if (i == 9) blocks_done = 1'b0;
      do_cmd(V_IDX[i], V_ARG[i], V_SLOW[i], V_RSP[i], (i == 1) ? 3 : 0,
             (i < 5) ? "R2" : "R8");
      if (i == 9) begin
        // R10 stray response while waiting on blocks; R9 nothing issued yet
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int w = 0; w < 6; w++) begin
          @(negedge clk);
          chk(cmd_valid === 1'b0, "R9", "no command before blocks_done",
              32'(cmd_valid), 32'd0);
        end
        blocks_done = 1'b1;
        @(negedge clk);
        blocks_done = 1'b0;
      end
    end
    chk(done === 1'b1, "R10", "done after status", 32'(done), 32'd1);
    chk(error === 1'b0, "R10", "error low at done", 32'(error), 32'd0);

    // R10 stray response in done state issues nothing
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0 && done === 1'b1, "R10", "idle after done",
        {cmd_valid, done}, 32'd1);

    // R11 restart from done
    pulse_start();
    chk(done === 1'b0, "R11", "done cleared", 32'(done), 32'd0);
    do_cmd(6'd0, 32'h0, 1'b1, 32'h0, 0, "R11");
    do_cmd(6'd1, 32'h00FF8000, 1'b1, 32'h80FF8000, 0, "R11");

    // R4 exhaustion: limit 3, never ready
    do_reset();
    retry_limit = 8'd3;
    pulse_start();
    do_cmd(6'd0, 32'h0, 1'b1, 32'h0, 0, "R4");
    for (int p = 0; p < 3; p++) begin
      chk(error === 1'b0, "R4", "error before limit", 32'(error), 32'd0);
      do_cmd(6'd1, 32'h00FF8000, 1'b1, 32'h0, 0, "R3");
    end
    chk(error === 1'b1, "R4", "error at limit", 32'(error), 32'd1);
    pulse_start();
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      chk(cmd_valid === 1'b0 && error === 1'b1 && done === 1'b0, "R4",
          "halted", {cmd_valid, error, done}, 32'd2);
    end

    // R4 ready on the last allowed poll wins over exhaustion
    do_reset();
    retry_limit = 8'd2;
    pulse_start();
    do_cmd(6'd0, 32'h0, 1'b1, 32'h0, 0, "R4");
    do_cmd(6'd1, 32'h00FF8000, 1'b1, 32'h0, 0, "R3");
    do_cmd(6'd1, 32'h00FF8000, 1'b1, 32'h80000000, 0, "R4");
    chk(error === 1'b0, "R4", "no error when ready on last", 32'(error), 32'd0);
    do_cmd(6'd2, 32'h0, 1'b1, 32'h0, 0, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule